// File: doc/BRIEF.md
# Two-Step-Clear Watchdog Timer

This block watches for a stalled program. It counts a slow timebase: the overflow signal of a general timer. That signal is brought into the system clock domain, divided by two, and fed to a three-stage toggle counter. If software lets the counter run through its eighth advance, the block raises a chip reset request. The request stays raised until the system reset is applied.

Software keeps the watchdog quiet with a two-write sequence on the register bus. The first write places the unlock key 0xF at the interrupt-flag address, which arms the clear. A later write of any value to the power-saving address completes the clear. Only when both writes come in that order do the counter and the arm latch return to zero. Entering stop mode holds the whole watchdog at zero.

Top module: `twostep_wdog`

## Requirements
- R1: While `rst_n` is low, the counter, the divide-by-two stage, the arm latch and `rst_req_o` are all zero.
- R2: The counter advances once for every two rising edges of `wclk_i`, seen through a two-flop synchroniser. The first rising edge after reset or after stop mode produces an advance.
- R3: Starting from zero, the eighth advance asserts `rst_req_o`. The counter is three bits wide, so it overflows on going from 7 back to 0.
- R4: A write with `wr_addr_i` equal to `FLAG_ADDR` (default 0x0A) and `wr_data_i` equal to 0xF sets the arm latch.
- R5: A write to `PWR_ADDR` (default 0x08) while the arm latch is set clears both the counter and the arm latch in the same clock. If an advance arrives in that same clock, the clear wins.
- R6: A write to `PWR_ADDR` while the arm latch is clear has no effect on the counter.
- R7: The arm latch is left unchanged by a write to any other address. It is also left unchanged by a write to `FLAG_ADDR` with data other than 0xF. Only reset, stop mode or a completed clear drop it.
- R8: While `stop_i` is high:
  - the counter, the divider and the arm latch are held at zero;
  - edges on `wclk_i` cause no advance;
  - no overflow can occur.
- R9: Once set, `rst_req_o` stays high, whatever writes or timebase edges follow, until `rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on/system reset |
| wclk_i | input | 1 | Timer overflow timebase, asynchronous to `clk` |
| stop_i | input | 1 | Stop mode active; holds the watchdog cleared |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rst_req_o | output | 1 | Chip reset request, sticky until reset |

## Verification
The assertions make three assumptions about the inputs:
- The timebase is slow compared with `clk`. Each high and each low phase of `wclk_i` lasts at least two system clocks, so that a synchronised rising edge is never seen on two consecutive cycles.
- Each write strobe lasts exactly one clock.
- Reset is held for several clocks.

The stimulus keeps within these limits. Every timebase pulse is driven high for four clocks and low for four clocks, away from the active edge. Each write is a single-clock strobe. Every table row begins from a fresh reset, so the expected count can be derived from the number of pulses alone.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Synchroniser, edge detector and divide-by-two state
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic div;
    } wsync_st_t;

    // Arm latch state
    typedef struct packed {
        logic arm;
    } unlock_st_t;

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_i,
    input  logic stop_i,
    output logic tick_o
);

    wsync_st_t st_d, st_q;
    logic      rise;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = wclk_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise    = st_q.s2 & ~st_q.s3;
        if (stop_i) begin
            st_d.div = 1'b0;
        end else begin
            st_d.div = st_q.div ^ rise;
        end
        tick_o = rise & ~st_q.div & ~stop_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a divided advance never repeats on the next clock
    a_r2_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R8: nothing advances while stopped
    a_r8_no_tick_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> !tick_o);

endmodule

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter int               ADDR_W    = 5,
    parameter int               DATA_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 5'h0A,
    parameter logic [ADDR_W-1:0] PWR_ADDR  = 5'h08,
    parameter logic [DATA_W-1:0] KEY       = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              clr_o
);

    unlock_st_t st_d, st_q;
    logic       key_wr;
    logic       pwr_wr;

    always_comb begin
        st_d   = st_q;
        key_wr = wr_en_i && (wr_addr_i == FLAG_ADDR) && (wr_data_i == KEY);
        pwr_wr = wr_en_i && (wr_addr_i == PWR_ADDR);
        clr_o  = pwr_wr && st_q.arm && !stop_i;
        if (stop_i) begin
            st_d.arm = 1'b0;
        end else if (clr_o) begin
            st_d.arm = 1'b0;
        end else if (key_wr) begin
            st_d.arm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the key at the flag address arms the clear
    a_r4_arm_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == FLAG_ADDR && wr_data_i == KEY && !stop_i) |=> st_q.arm);

    // R5: a completed clear drops the arm latch
    a_r5_arm_drop: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !st_q.arm);

    // R7: unrelated writes keep the latch armed
    a_r7_arm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.arm && !stop_i && !(wr_en_i && wr_addr_i == PWR_ADDR)) |=> st_q.arm);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic tick_i,
    input  logic clr_i,
    output logic req_o
);

    typedef struct packed {
        logic [STAGES-1:0] cnt;
        logic              req;
    } cnt_st_t;

    cnt_st_t           st_d, st_q;
    logic [STAGES:0]   carry;
    logic [STAGES-1:0] toggled;

    assign carry[0] = tick_i;

    // Each stage toggles when every lower stage is one
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        assign toggled[g]  = st_q.cnt[g] ^ carry[g];
        assign carry[g+1]  = carry[g] & st_q.cnt[g];
    end

    always_comb begin
        st_d = st_q;
        if (stop_i || clr_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = toggled;
            if (carry[STAGES]) st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    // R3: the last advance from all-ones requests a reset
    a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && !stop_i && (&st_q.cnt)) |=> req_o);

    // R9: the request is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> req_o);

    // R5: a clear empties the counter
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0));

    // R8: stop holds the counter at zero
    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/twostep_wdog.sv
module twostep_wdog #(
    parameter int                ADDR_W    = 5,
    parameter int                DATA_W    = 4,
    parameter int                STAGES    = 3,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 5'h0A,
    parameter logic [ADDR_W-1:0] PWR_ADDR  = 5'h08,
    parameter logic [DATA_W-1:0] KEY       = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wclk_i,
    input  logic              stop_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              rst_req_o
);

    logic tick;
    logic clr;

    wdog_tick_gen u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .wclk_i (wclk_i),
        .stop_i (stop_i),
        .tick_o (tick)
    );

    wdog_unlock #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FLAG_ADDR (FLAG_ADDR),
        .PWR_ADDR  (PWR_ADDR),
        .KEY       (KEY)
    ) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_i    (stop_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .clr_o     (clr)
    );

    wdog_counter #(
        .STAGES (STAGES)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .stop_i (stop_i),
        .tick_i (tick),
        .clr_i  (clr),
        .req_o  (rst_req_o)
    );

    // R1: no request can be seen right after reset releases
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> !rst_req_o);

endmodule

// File: tb/twostep_wdog_bench.sv
module twostep_wdog_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [4:0] wr_addr_i = '0;
    logic [3:0] wr_data_i = '0;
    logic       rst_req_o;

    int tests = 0;
    int fails = 0;

    localparam logic [4:0] A_FLAG  = 5'h0A;
    localparam logic [4:0] A_PWR   = 5'h08;
    localparam logic [4:0] A_OTHER = 5'h11;

    always #2 clk = ~clk;

    twostep_wdog u_twostep_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .wclk_i    (wclk_i),
        .stop_i    (stop_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rst_req_o (rst_req_o)
    );

    // act: 0 none, 1 key+pwr, 2 pwr only, 3 wrong key+pwr,
    //      4 key+other+pwr, 5 pwr then key, 6 key+flag(0x3)+pwr
    typedef struct packed {
        logic [5:0] pre;
        logic [2:0] act;
        logic [5:0] post;
        logic       exp;
    } vec_t;

    localparam vec_t TABLE [9] = '{
        '{6'd14, 3'd0, 6'd0,  1'b0},  // R2: 7 advances
        '{6'd15, 3'd0, 6'd0,  1'b1},  // R3: 8 advances
        '{6'd14, 3'd1, 6'd14, 1'b0},  // R5
        '{6'd14, 3'd1, 6'd15, 1'b1},  // R5 then R3
        '{6'd14, 3'd2, 6'd2,  1'b1},  // R6
        '{6'd14, 3'd3, 6'd2,  1'b1},  // R4 wrong key
        '{6'd14, 3'd4, 6'd14, 1'b0},  // R7 other address
        '{6'd14, 3'd5, 6'd2,  1'b1},  // R6 wrong order
        '{6'd14, 3'd6, 6'd14, 1'b0}   // R7 flag with other data
    };

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rst_req_o=%b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wclk_i = 1'b0; stop_i = 1'b0; wr_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wclk_i = 1'b1;
            repeat (4) @(negedge clk);
            wclk_i = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", rst_req_o, 1'b0);
        rst_n = 1'b1;

        foreach (TABLE[k]) begin
            do_reset();
            pulses(int'(TABLE[k].pre));
            case (TABLE[k].act)
                3'd1: begin wr(A_FLAG, 4'hF); wr(A_PWR, 4'h0); end
                3'd2: wr(A_PWR, 4'h0);
                3'd3: begin wr(A_FLAG, 4'hE); wr(A_PWR, 4'h0); end
                3'd4: begin wr(A_FLAG, 4'hF); wr(A_OTHER, 4'h5); wr(A_PWR, 4'h0); end
                3'd5: begin wr(A_PWR, 4'h0); wr(A_FLAG, 4'hF); end
                3'd6: begin wr(A_FLAG, 4'hF); wr(A_FLAG, 4'h3); wr(A_PWR, 4'h0); end
                default: ;
            endcase
            pulses(int'(TABLE[k].post));
            check($sformatf("R2/R3/R4/R5/R6/R7 row %0d", k), rst_req_o, TABLE[k].exp);
        end

        // R9: request survives clears and further edges
        do_reset();
        pulses(15);
        check("R3 overflow", rst_req_o, 1'b1);
        wr(A_FLAG, 4'hF); wr(A_PWR, 4'h0);
        pulses(3);
        check("R9 sticky", rst_req_o, 1'b1);

        // R1: reset drops the request
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears request", rst_req_o, 1'b0);
        rst_n = 1'b1;

        // R8: stop holds counter and divider at zero
        do_reset();
        pulses(14);
        @(negedge clk); stop_i = 1'b1;
        pulses(10);
        check("R8 no overflow in stop", rst_req_o, 1'b0);
        @(negedge clk); stop_i = 1'b0;
        pulses(14);
        check("R8 counter restarted", rst_req_o, 1'b0);
        pulses(1);
        check("R8 divider restarted", rst_req_o, 1'b1);

        // R8: stop drops the arm latch
        do_reset();
        wr(A_FLAG, 4'hF);
        @(negedge clk); stop_i = 1'b1;
        repeat (2) @(negedge clk);
        stop_i = 1'b0;
        pulses(14);
        wr(A_PWR, 4'h0);
        pulses(1);
        check("R8 arm dropped by stop", rst_req_o, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule